// File: doc/BRIEF.md
# Time-Slot Channel Mapper

This block sits on the receive side of one T1 or E1 serial link and spreads the incoming payload bits over a set of logical HDLC channels. It consumes one line bit per cycle in which `rx_valid` is high, together with a marker that flags the first bit of each frame. A running position counter tells which time slot and which bit of that slot the current bit belongs to. A slot table then says whether the slot is in use and which channel owns it. Every delivered bit leaves the block as a channel number, the data bit and a strobe. An octet flag marks the first delivered bit of each slot, so that a downstream transparent channel can rebuild octets that line up with the slots.

The slot table has one entry per slot. Each entry holds an in-use bit and a channel number. A second, per-channel table selects the 64 kbit/s slot format (all eight bits carry data) or the 56 kbit/s format (the last bit of each slot is discarded). A channel may own any set of slots, and the slots need not be adjacent. Software writes a pending copy of both tables. The link mode (T1 or E1, channelised or clear-channel) is sampled from level inputs. Table contents and link mode take effect together at the next frame start. In clear-channel mode the whole frame, including the framing positions, goes to channel 0.

Top module: `slot_chan_mapper`

## Requirements
- R1: After reset all outputs are 0. The reset mode is T1 channelised with every slot unused, so no strobe appears before the first frame start, whatever the mode inputs are.
- R2: T1 channelised mode: a frame is one framing bit followed by 24 slots of 8 bits. The framing bit gives no strobe. Bits of slot k (k = 0..23, numbered in arrival order after the framing bit) use table entry k.
- R3: E1 channelised mode: a frame is 32 slots of 8 bits, starting with slot 0 on the frame-start bit. Slot 0 never gives a strobe. Slot k (k = 1..31) uses table entry k.
- R4: The channel of each slot is taken from its own entry, so non-adjacent slots may share a channel. A slot whose in-use bit is 0 gives no strobe.
- R5: When the owning channel is set to the 56 kbit/s format, the bit at position 7 of a slot gives no strobe. Positions are counted 0..7 in arrival order. Bits 0..6 are delivered.
- R6: Clear-channel mode: every bit, framing positions included, is delivered on channel 0. The octet flag is high on the frame-start bit and on every eighth bit after it, counting across frame ends until the next frame start.
- R7: In channelised mode the octet flag is high exactly on a delivered bit at slot position 0, and it is 0 whenever `out_valid` is 0.
- R8: Table writes, format writes and the mode inputs take effect at the next frame start (`rx_valid` and `rx_fs` both high). A write made in that same cycle is included. Bits before that point use the old settings.
- R9: The outputs for a bit appear one clock after the bit is sampled, and `out_bit` equals the sampled bit.
- R10: A frame start restarts the counting at any point in a frame. Without a frame start, the count wraps after 193 bits (T1) or 256 bits (E1).
- R11: A cycle with `rx_valid` low does not advance the position and gives no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_e1 | input | 1 | Link type sampled at frame start: 1 = E1, 0 = T1 |
| cfg_clear | input | 1 | Clear-channel mode sampled at frame start |
| tbl_wr | input | 1 | Write strobe for the pending slot table |
| tbl_slot | input | 5 | Slot entry to write |
| tbl_en | input | 1 | In-use bit to write |
| tbl_chan | input | CHW | Channel number to write |
| fmt_wr | input | 1 | Write strobe for the pending format table |
| fmt_chan | input | CHW | Channel whose format is written |
| fmt_56 | input | 1 | 1 = 56 kbit/s format, 0 = 64 kbit/s format |
| rx_bit | input | 1 | Line data bit |
| rx_valid | input | 1 | Line bit present this cycle |
| rx_fs | input | 1 | Current bit is the first bit of a frame |
| out_valid | output | 1 | Strobe: a payload bit is delivered |
| out_chan | output | CHW | Channel of the delivered bit |
| out_bit | output | 1 | Delivered data bit |
| out_octet | output | 1 | Delivered bit starts an octet |

## Verification
The case of interest is a table or format write that falls in the same cycle as a frame start. At that point the pending copy is being modified and copied into the active copy on the same edge. The bench provokes this by raising `tbl_wr` and `fmt_wr` together with the frame-start bit. It then confirms that the first slots of the new frame already carry the written channel and format. A second case is a table rewrite in the middle of a frame. There the bench checks bit by bit that the rest of the frame still follows the old assignment.

// File: rtl/scm_pkg.sv
package scm_pkg;
    localparam int SLOT_W        = 5;
    localparam int BIT_W         = 3;
    localparam int NSLOT         = 1 << SLOT_W;
    localparam int T1_LAST_SLOT  = 23;
    localparam int LAST_BIT      = (1 << BIT_W) - 1;

    typedef struct packed {
        logic              fbit;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic [BIT_W-1:0]  oct;
    } pos_t;
endpackage

// File: rtl/scm_position.sv
module scm_position
    import scm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic fs,
    input  logic is_e1,
    output pos_t cur
);
    pos_t pos_q, pos_d, nxt;

    always_comb begin
        cur = pos_q;
        if (fs) begin
            cur.fbit = ~is_e1;
            cur.slot = '0;
            cur.bitn = '0;
            cur.oct  = '0;
        end
        nxt     = cur;
        nxt.oct = cur.oct + 1'b1;
        if (cur.fbit) begin
            nxt.fbit = 1'b0;
            nxt.slot = '0;
            nxt.bitn = '0;
        end else if (cur.bitn == BIT_W'(LAST_BIT)) begin
            nxt.bitn = '0;
            if (!is_e1 && cur.slot == SLOT_W'(T1_LAST_SLOT)) begin
                nxt.fbit = 1'b1;
                nxt.slot = '0;
            end else begin
                nxt.slot = cur.slot + 1'b1;
            end
        end else begin
            nxt.bitn = cur.bitn + 1'b1;
        end
        pos_d = adv ? nxt : pos_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            pos_q.fbit <= 1'b1;
        end else begin
            pos_q <= pos_d;
        end
    end
endmodule

// File: rtl/scm_table.sv
module scm_table
    import scm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              wr,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic              fmt_wr,
    input  logic [CHW-1:0]    fmt_ch,
    input  logic              fmt_56,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_en,
    output logic [CHW-1:0]    rd_ch,
    output logic              rd_56
);
    typedef struct packed {
        logic [NSLOT-1:0]          p_en;
        logic [NSLOT-1:0][CHW-1:0] p_ch;
        logic [NCH-1:0]            p_f;
        logic [NSLOT-1:0]          a_en;
        logic [NSLOT-1:0][CHW-1:0] a_ch;
        logic [NCH-1:0]            a_f;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        if (wr) begin
            tbl_d.p_en[wr_slot] = wr_en;
            tbl_d.p_ch[wr_slot] = wr_ch;
        end
        if (fmt_wr) begin
            tbl_d.p_f[fmt_ch] = fmt_56;
        end
        if (commit) begin
            tbl_d.a_en = tbl_d.p_en;
            tbl_d.a_ch = tbl_d.p_ch;
            tbl_d.a_f  = tbl_d.p_f;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_en = tbl_q.a_en[rd_slot];
    assign rd_ch = tbl_q.a_ch[rd_slot];
    assign rd_56 = tbl_q.a_f[rd_ch];
endmodule

// File: rtl/slot_chan_mapper.sv
module slot_chan_mapper
    import scm_pkg::*;
#(
    parameter  int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_e1,
    input  logic              cfg_clear,
    input  logic              tbl_wr,
    input  logic [SLOT_W-1:0] tbl_slot,
    input  logic              tbl_en,
    input  logic [CHW-1:0]    tbl_chan,
    input  logic              fmt_wr,
    input  logic [CHW-1:0]    fmt_chan,
    input  logic              fmt_56,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              rx_fs,
    output logic              out_valid,
    output logic [CHW-1:0]    out_chan,
    output logic              out_bit,
    output logic              out_octet
);
    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] chan;
        logic           dbit;
        logic           octet;
        logic           e1;
        logic           clear;
    } st_t;

    st_t  st_q, st_d;
    pos_t cur;
    logic commit, eff_e1, eff_clear;
    logic rd_en, rd_56;
    logic [CHW-1:0] rd_ch;
    logic drop_pos;

    logic mode_clear_q, mode_e1_q;
    logic [SLOT_W-1:0] cur_slot;

    assign commit    = rx_valid & rx_fs;
    assign eff_e1    = commit ? cfg_e1    : st_q.e1;
    assign eff_clear = commit ? cfg_clear : st_q.clear;

    scm_position u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rx_valid),
        .fs    (commit),
        .is_e1 (eff_e1),
        .cur   (cur)
    );

    scm_table #(.NCH(NCH), .CHW(CHW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr      (tbl_wr),
        .wr_slot (tbl_slot),
        .wr_en   (tbl_en),
        .wr_ch   (tbl_chan),
        .fmt_wr  (fmt_wr),
        .fmt_ch  (fmt_chan),
        .fmt_56  (fmt_56),
        .rd_slot (cur.slot),
        .rd_en   (rd_en),
        .rd_ch   (rd_ch),
        .rd_56   (rd_56)
    );

    // framing positions in channelised mode: T1 framing bit, E1 slot 0
    assign drop_pos = cur.fbit | (eff_e1 & (cur.slot == '0));

    always_comb begin
        st_d       = '0;
        st_d.e1    = eff_e1;
        st_d.clear = eff_clear;
        if (rx_valid) begin
            if (eff_clear) begin
                st_d.valid = 1'b1;
                st_d.dbit  = rx_bit;
                st_d.octet = (cur.oct == '0);
            end else if (!drop_pos && rd_en &&
                         !(rd_56 && cur.bitn == BIT_W'(LAST_BIT))) begin
                st_d.valid = 1'b1;
                st_d.chan  = rd_ch;
                st_d.dbit  = rx_bit;
                st_d.octet = (cur.bitn == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_chan     = st_q.chan;
    assign out_bit      = st_q.dbit;
    assign out_octet    = st_q.octet;
    assign mode_clear_q = st_q.clear;
    assign mode_e1_q    = st_q.e1;
    assign cur_slot     = cur.slot;
endmodule

// File: rtl/slot_chan_mapper_chk.sv
module slot_chan_mapper_chk #(
    parameter  int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_valid,
    input logic           rx_fs,
    input logic           out_valid,
    input logic [CHW-1:0] out_chan,
    input logic           out_octet,
    input logic           mode_clear_q,
    input logic           mode_e1_q,
    input logic [4:0]     cur_slot
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (rx_valid && rx_fs) seen_q <= 1'b1;
    end

    a_r1_quiet_before_fs: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !out_valid);

    a_r11_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !out_valid);

    a_r9_strobe_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rx_valid));

    a_r7_octet_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_octet |-> out_valid);

    a_r6_clear_on_chan0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_clear_q) |-> (out_chan == '0));

    a_r2_t1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_e1_q |-> (cur_slot <= 5'd23));
endmodule

bind slot_chan_mapper slot_chan_mapper_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_fs        (rx_fs),
    .out_valid    (out_valid),
    .out_chan     (out_chan),
    .out_octet    (out_octet),
    .mode_clear_q (mode_clear_q),
    .mode_e1_q    (mode_e1_q),
    .cur_slot     (cur_slot)
);

// File: tb/slot_chan_mapper_test.sv
module slot_chan_mapper_test;
    localparam int NCH = 8;
    localparam int CHW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_e1 = 1'b0, cfg_clear = 1'b0;
    logic tbl_wr = 1'b0, tbl_en = 1'b0;
    logic [4:0] tbl_slot = '0;
    logic [CHW-1:0] tbl_chan = '0, fmt_chan = '0;
    logic fmt_wr = 1'b0, fmt_56 = 1'b0;
    logic rx_bit = 1'b0, rx_valid = 1'b0, rx_fs = 1'b0;
    logic out_valid, out_bit, out_octet;
    logic [CHW-1:0] out_chan;

    always #2 clk = ~clk;

    slot_chan_mapper #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_e1(cfg_e1), .cfg_clear(cfg_clear),
        .tbl_wr(tbl_wr), .tbl_slot(tbl_slot), .tbl_en(tbl_en), .tbl_chan(tbl_chan),
        .fmt_wr(fmt_wr), .fmt_chan(fmt_chan), .fmt_56(fmt_56),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_fs(rx_fs),
        .out_valid(out_valid), .out_chan(out_chan), .out_bit(out_bit),
        .out_octet(out_octet)
    );

    int vectors = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hACE1;

    int p_en[32], p_ch[32], p_f[8];
    int a_en[32], a_ch[32], a_f[8];
    int a_e1 = 0, a_clr = 0, nidx = 0, noct = 0;

    function automatic logic rnd_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic cmp(input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic set_slot(input int s, input int en, input int ch);
        tbl_wr = 1'b1; tbl_slot = 5'(s); tbl_en = en[0]; tbl_chan = CHW'(ch);
    endtask

    task automatic set_fmt(input int ch, input int f);
        fmt_wr = 1'b1; fmt_chan = CHW'(ch); fmt_56 = f[0];
    endtask

    // Applies one cycle of stimulus and checks the outputs one clock later.
    task automatic step(input bit v, input bit b, input bit fs);
        int ev = 0, ec = 0, eo = 0;
        int cidx, coct, s, bb;
        bit drop;
        if (tbl_wr) begin p_en[tbl_slot] = tbl_en; p_ch[tbl_slot] = tbl_chan; end
        if (fmt_wr) p_f[fmt_chan] = fmt_56;
        if (v && fs) begin
            for (int i = 0; i < 32; i++) begin a_en[i] = p_en[i]; a_ch[i] = p_ch[i]; end
            for (int i = 0; i < 8; i++) a_f[i] = p_f[i];
            a_e1 = cfg_e1; a_clr = cfg_clear;
        end
        if (v) begin
            cidx = fs ? 0 : nidx;
            coct = fs ? 0 : noct;
            nidx = (cidx + 1) % (a_e1 ? 256 : 193);
            noct = (coct + 1) % 8;
            if (a_clr) begin
                ev = 1; ec = 0; eo = (coct == 0);
            end else begin
                drop = 1'b0; s = 0; bb = 0;
                if (a_e1) begin s = cidx / 8; bb = cidx % 8; drop = (s == 0); end
                else if (cidx == 0) drop = 1'b1;
                else begin s = (cidx - 1) / 8; bb = (cidx - 1) % 8; end
                if (!drop && a_en[s] != 0 && !(a_f[a_ch[s]] != 0 && bb == 7)) begin
                    ev = 1; ec = a_ch[s]; eo = (bb == 0);
                end
            end
        end
        rx_valid = v; rx_bit = b; rx_fs = fs;
        @(negedge clk);
        tbl_wr = 1'b0; fmt_wr = 1'b0; rx_valid = 1'b0; rx_fs = 1'b0;
        vectors++;
        cmp("out_valid", int'(out_valid), ev);
        cmp("out_octet", int'(out_octet), eo);
        if (ev != 0) begin
            cmp("out_chan", int'(out_chan), ec);
            cmp("out_bit", int'(out_bit), int'(b));
        end
    endtask

    task automatic run_bits(input int n, input bit fs_first, input int gap);
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && i % gap == gap - 1) step(1'b0, 1'b0, 1'b0);
            step(1'b1, rnd_bit(), fs_first && i == 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin p_en[i] = 0; p_ch[i] = 0; a_en[i] = 0; a_ch[i] = 0; end
        for (int i = 0; i < 8; i++) begin p_f[i] = 0; a_f[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        vectors++;
        cmp("reset out_valid", int'(out_valid), 0);
        cmp("reset out_octet", int'(out_octet), 0);
        cmp("reset out_chan", int'(out_chan), 0);
        cmp("reset out_bit", int'(out_bit), 0);
        // R1: no strobe before the first frame start, even with clear mode requested
        cfg_clear = 1'b1;
        run_bits(40, 1'b0, 0);
        cfg_clear = 1'b0;

        // Program a sparse, non-adjacent T1 assignment
        for (int s = 0; s < 24; s++) begin set_slot(s, (s % 5) != 4, (s * 3) % 8); step(1'b0, 1'b0, 1'b0); end
        set_fmt(2, 1); step(1'b0, 1'b0, 1'b0);
        set_fmt(5, 1); step(1'b0, 1'b0, 1'b0);

        cur_req = "R2 R4 R5 R7 R9";
        for (int f = 0; f < 3; f++) run_bits(193, 1'b1, 0);

        // R8: rewrite table mid-frame, old table must hold until the next frame start
        cur_req = "R8";
        run_bits(60, 1'b1, 0);
        for (int s = 0; s < 24; s++) begin set_slot(s, 1, s % 8); step(1'b1, rnd_bit(), 1'b0); end
        set_fmt(2, 0); step(1'b1, rnd_bit(), 1'b0);
        run_bits(108, 1'b0, 0);
        run_bits(193, 1'b1, 0);

        // R3: E1 channelised
        cur_req = "R3 R4 R5";
        for (int s = 0; s < 32; s++) begin set_slot(s, (s % 7) != 3, (s * 5 + 1) % 8); step(1'b0, 1'b0, 1'b0); end
        set_fmt(3, 1); step(1'b0, 1'b0, 1'b0);
        cfg_e1 = 1'b1;
        for (int f = 0; f < 2; f++) run_bits(256, 1'b1, 0);

        // R6: clear-channel in E1 then T1, including a wrap without frame start
        cur_req = "R6";
        cfg_clear = 1'b1;
        run_bits(256, 1'b1, 0);
        cfg_e1 = 1'b0;
        run_bits(193, 1'b1, 0);
        run_bits(200, 1'b1, 0);
        cfg_clear = 1'b0;

        // R11: idle cycles inside a T1 frame
        cur_req = "R11";
        run_bits(193, 1'b1, 3);
        run_bits(193, 1'b1, 5);

        // R10: early frame start, then free wrapping in T1 and E1
        cur_req = "R10";
        run_bits(100, 1'b1, 0);
        run_bits(2 * 193 + 50, 1'b1, 0);
        cfg_e1 = 1'b1;
        run_bits(77, 1'b1, 0);
        run_bits(2 * 256 + 40, 1'b1, 0);
        cfg_e1 = 1'b0;

        // R8: write in the same cycle as the frame start is included
        cur_req = "R8 same-cycle";
        run_bits(20, 1'b1, 0);
        set_slot(0, 1, 7); set_fmt(7, 1);
        step(1'b1, rnd_bit(), 1'b1);
        run_bits(192, 1'b0, 0);
        set_slot(1, 0, 0);
        step(1'b1, rnd_bit(), 1'b1);
        run_bits(192, 1'b0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: got %0d cycles expected completion", 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule